// File: doc/BRIEF.md
# NAND Source-Synchronous DDR Host Sequencer

This block is the host side of a NAND flash link running in its double-data-rate, source-synchronous mode. It takes one request at a time from a user port and turns it into pin activity. A request is a command byte, an address byte, a write burst or a read burst. The block generates the device clock, the direction line and the two phase-select lines (command latch and address latch). It drives the data bus and the data strobe on writes. On reads it captures each incoming byte on every strobe transition.

Every timing figure is counted in system-clock cycles from configuration inputs. `cfg_half` sets one half of the device clock period and must be at least 2. `cfg_tcad` sets the idle spacing that follows every command or address cycle and must be at least 1. Setting these two inputs lets one block cover all four timing modes (a 50, 30, 20 or 15 ns period, for 40 to 133 MT/s) from a single fast system clock.

The direction line is high for host-to-device transfers and low for device-to-host transfers. It changes only while both phase-select lines are low. The device clock runs only while at least one phase-select line is high.

Top module: `nand_ddr_host`

## Requirements
- R1: After reset: `busy` is 0, `req_ready` is 1, `nd_clk` is 0, `nd_cle`=`nd_ale`=0, `nd_wr_n` is 1, `nd_dq_oe`=`nd_dqs_oe`=0 and `rd_valid` is 0.
- R2: A command request (`req_op`=0) raises `nd_cle` alone. An address request (`req_op`=1) raises `nd_ale` alone. Either one lasts exactly one device clock period and drives `req_byte` on `nd_dq_out`. `nd_dqs_oe` stays low throughout.
- R3: After each command or address clock period, both phase-select lines stay low for exactly `cfg_tcad` cycles before `busy` falls. When two such requests are issued back to back, their rising phase-select edges are 2·`cfg_half`+`cfg_tcad`+1 cycles apart.
- R4: A write burst (`req_op`=2) holds `nd_cle`=`nd_ale`=1 for `req_len`/2 clock periods. It pulses `wr_take` once per 16-bit word. It sends the low byte of each `wr_data` word on the rising strobe edge and the high byte on the falling edge. The strobe follows `nd_clk` one system cycle late.
- R5: A read burst (`req_op`=3, with `req_len` even and nonzero) holds both phase-select lines high for `req_len`/2 clock periods. It delivers the byte present on `nd_dq_in` at each `nd_dqs_in` transition, in arrival order, as one-cycle `rd_valid` pulses.
- R6: A read completes only after `req_len` bytes have been captured, even when strobes arrive after the device clock has stopped. Any strobe transitions beyond that count produce no `rd_valid` pulse.
- R7: When the bus direction reverses, `nd_wr_n` changes while both phase-select lines are low. The next phase-select rise then follows exactly 2·`cfg_half` cycles later, with the device clock stopped.
- R8: `nd_clk` is high only while `nd_cle` or `nd_ale` is high.
- R9: Each device clock period lasts 2·`cfg_half` system cycles, with `nd_clk` high for the first `cfg_half` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | HALF_W | Device clock half period in system cycles (≥2) |
| cfg_tcad | input | CAD_W | Idle spacing after a command/address cycle (≥1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 0 command, 1 address, 2 write burst, 3 read burst |
| req_byte | input | DQ_W | Command or address byte |
| req_len | input | LEN_W | Burst length in bytes (even) |
| wr_data | input | 2·DQ_W | Next write word, low byte sent first |
| wr_take | output | 1 | Current wr_data word is consumed at this clock edge |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | DQ_W | Read byte |
| busy | output | 1 | A request is in progress |
| nd_clk | output | 1 | Device clock |
| nd_wr_n | output | 1 | Direction: 1 host-to-device, 0 device-to-host |
| nd_cle | output | 1 | Command latch / data phase select |
| nd_ale | output | 1 | Address latch / data phase select |
| nd_dq_out | output | DQ_W | Data bus driven value |
| nd_dq_oe | output | 1 | Data bus drive enable |
| nd_dq_in | input | DQ_W | Data bus received value |
| nd_dqs_out | output | 1 | Strobe driven value |
| nd_dqs_oe | output | 1 | Strobe drive enable |
| nd_dqs_in | input | 1 | Strobe received value |

## Verification
The bench runs single command cycles and back-to-back address cycles under two different half-period and spacing settings. Checking these exposes any miscount in the clock period and in the command/address spacing. Write and read bursts alternate, so the direction turnaround is measured in both directions and kept apart from the no-reversal case. Reads are run three ways: with a prompt strobe, with a strobe that lags past the end of the clock, and with surplus strobe edges. The lagging case separates "finish when the clock stops" from "finish when the count is met". The surplus case exposes a capture that does not stop at the programmed length.

// File: rtl/nddr_pkg.sv
package nddr_pkg;
  localparam logic [1:0] OP_CMD   = 2'd0;
  localparam logic [1:0] OP_ADDR  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_READ  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_CA,
    ST_CAD,
    ST_DATA,
    ST_DRAIN
  } seq_st_t;
endpackage

// File: rtl/nddr_seq.sv
module nddr_seq
  import nddr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int CAD_W  = 8,
  parameter int LEN_W  = 12,
  parameter int DQ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [CAD_W-1:0]  cfg_tcad,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [DQ_W-1:0]   req_byte,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              rd_done,
  output logic              req_ready,
  output logic              busy,
  output logic              nd_clk,
  output logic              nd_wr_n,
  output logic              nd_cle,
  output logic              nd_ale,
  output logic              ca_act,
  output logic [DQ_W-1:0]   ca_byte,
  output logic              wr_act,
  output logic              load_pair,
  output logic              rd_arm,
  output logic              rd_clr,
  output logic [LEN_W-1:0]  len_o
);
  localparam int CNT_W = (HALF_W + 1 > CAD_W) ? HALF_W + 1 : CAD_W;

  seq_st_t            st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               ph_q, ph_n;
  logic [LEN_W-1:0]   pr_q, pr_n;
  logic [1:0]         op_q, op_n;
  logic [DQ_W-1:0]    byte_q, byte_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic               dir_q, dir_n;
  logic               go;
  logic [1:0]         go_op;
  logic [LEN_W-1:0]   go_len;
  logic [CNT_W-1:0]   half_m1, full_m1, tcad_m1;

  assign half_m1 = CNT_W'(cfg_half) - CNT_W'(1);
  assign full_m1 = (CNT_W'(cfg_half) << 1) - CNT_W'(1);
  assign tcad_m1 = CNT_W'(cfg_tcad) - CNT_W'(1);

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    ph_n      = ph_q;
    pr_n      = pr_q;
    op_n      = op_q;
    byte_n    = byte_q;
    len_n     = len_q;
    dir_n     = dir_q;
    load_pair = 1'b0;
    go        = 1'b0;
    go_op     = op_q;
    go_len    = len_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_n   = req_op;
          byte_n = req_byte;
          len_n  = req_len;
          if ((req_op != OP_READ) != dir_q) begin
            dir_n = ~dir_q;
            st_n  = ST_TURN;
            cnt_n = full_m1;
          end else begin
            go     = 1'b1;
            go_op  = req_op;
            go_len = req_len;
          end
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) go = 1'b1;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      ST_CA: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - CNT_W'(1);
        end else if (ph_q) begin
          ph_n  = 1'b0;
          cnt_n = half_m1;
        end else begin
          st_n  = ST_CAD;
          cnt_n = tcad_m1;
        end
      end
      ST_CAD: begin
        if (cnt_q == '0) st_n = ST_IDLE;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      ST_DATA: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - CNT_W'(1);
        end else if (ph_q) begin
          ph_n  = 1'b0;
          cnt_n = half_m1;
        end else if (pr_q != '0) begin
          ph_n      = 1'b1;
          cnt_n     = half_m1;
          pr_n      = pr_q - LEN_W'(1);
          load_pair = (op_q == OP_WRITE);
        end else begin
          st_n = (op_q == OP_READ) ? ST_DRAIN : ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (rd_done) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    if (go) begin
      ph_n  = 1'b1;
      cnt_n = half_m1;
      if (go_op == OP_CMD || go_op == OP_ADDR) begin
        st_n = ST_CA;
      end else begin
        st_n      = ST_DATA;
        pr_n      = (go_len >> 1) - LEN_W'(1);
        load_pair = (go_op == OP_WRITE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      pr_q   <= '0;
      op_q   <= OP_CMD;
      byte_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      ph_q   <= ph_n;
      pr_q   <= pr_n;
      op_q   <= op_n;
      byte_q <= byte_n;
      len_q  <= len_n;
      dir_q  <= dir_n;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign ca_act    = (st_q == ST_CA);
  assign ca_byte   = byte_q;
  assign wr_act    = (st_q == ST_DATA) && (op_q == OP_WRITE);
  assign rd_arm    = (st_q == ST_DATA || st_q == ST_DRAIN) && (op_q == OP_READ);
  assign rd_clr    = (st_q == ST_IDLE);
  assign len_o     = len_q;
  assign nd_clk    = ph_q;
  assign nd_wr_n   = dir_q;
  assign nd_cle    = (ca_act && op_q == OP_CMD)  || (st_q == ST_DATA);
  assign nd_ale    = (ca_act && op_q == OP_ADDR) || (st_q == ST_DATA);

  // cycles spent outside command/address since the last such cycle
  logic [CAD_W:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '1;
    else if (ca_act)           gap_q <= '0;
    else if (gap_q != '1)      gap_q <= gap_q + 1'b1;
  end

  AST_TCAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ca_act) |-> (gap_q >= {1'b0, cfg_tcad})); // R3
  AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_wr_n != $past(nd_wr_n)) |-> (!nd_cle && !nd_ale)); // R7
  AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    nd_clk |-> (nd_cle || nd_ale)); // R8
  AST_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (cfg_half >= HALF_W'(2) && cfg_tcad != '0)); // R9
  AST_LEN_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1]) |-> (!req_len[0] && req_len != '0)); // R5
endmodule

// File: rtl/nddr_wr_launch.sv
module nddr_wr_launch #(
  parameter int DQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2*DQ_W-1:0] wdata,
  input  logic              active,
  input  logic              nd_clk,
  output logic [DQ_W-1:0]   dq,
  output logic              dqs
);
  logic [2*DQ_W-1:0] pair_q;
  logic              dqs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      dqs_q  <= 1'b0;
    end else begin
      if (load) pair_q <= wdata;
      dqs_q <= active && nd_clk;
    end
  end

  // first half of each period carries the low byte
  assign dq  = nd_clk ? pair_q[DQ_W-1:0] : pair_q[2*DQ_W-1:DQ_W];
  assign dqs = dqs_q;
endmodule

// File: rtl/nddr_rd_capture.sv
module nddr_rd_capture #(
  parameter int DQ_W  = 8,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             clr,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dqs_in,
  input  logic [DQ_W-1:0]  dq_in,
  output logic             vld,
  output logic [DQ_W-1:0]  data,
  output logic             done
);
  logic             prev_q;
  logic [LEN_W-1:0] cnt_q;
  logic             vld_q;
  logic [DQ_W-1:0]  data_q;
  logic             take;

  assign take = arm && (dqs_in != prev_q) && (cnt_q != len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      prev_q <= dqs_in;
      vld_q  <= take;
      if (take) data_q <= dq_in;
      if (clr)       cnt_q <= '0;
      else if (take) cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign vld  = vld_q;
  assign data = data_q;
  assign done = (cnt_q == len_i);

  AST_RD_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && cnt_q == len_i) |=> !vld_q); // R6
endmodule

// File: rtl/nand_ddr_host.sv
module nand_ddr_host
  import nddr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int CAD_W  = 8,
  parameter int LEN_W  = 12,
  parameter int DQ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [CAD_W-1:0]  cfg_tcad,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [DQ_W-1:0]   req_byte,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [2*DQ_W-1:0] wr_data,
  output logic              wr_take,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              busy,
  output logic              nd_clk,
  output logic              nd_wr_n,
  output logic              nd_cle,
  output logic              nd_ale,
  output logic [DQ_W-1:0]   nd_dq_out,
  output logic              nd_dq_oe,
  input  logic [DQ_W-1:0]   nd_dq_in,
  output logic              nd_dqs_out,
  output logic              nd_dqs_oe,
  input  logic              nd_dqs_in
);
  logic             ca_act, wr_act, load_pair, rd_arm, rd_clr, rd_done;
  logic [DQ_W-1:0]  ca_byte, wr_byte;
  logic [LEN_W-1:0] len_q;

  nddr_seq #(.HALF_W(HALF_W), .CAD_W(CAD_W), .LEN_W(LEN_W), .DQ_W(DQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_tcad(cfg_tcad),
    .req_valid(req_valid), .req_op(req_op), .req_byte(req_byte), .req_len(req_len),
    .rd_done(rd_done), .req_ready(req_ready), .busy(busy),
    .nd_clk(nd_clk), .nd_wr_n(nd_wr_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
    .ca_act(ca_act), .ca_byte(ca_byte), .wr_act(wr_act), .load_pair(load_pair),
    .rd_arm(rd_arm), .rd_clr(rd_clr), .len_o(len_q)
  );

  nddr_wr_launch #(.DQ_W(DQ_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(load_pair), .wdata(wr_data),
    .active(wr_act), .nd_clk(nd_clk), .dq(wr_byte), .dqs(nd_dqs_out)
  );

  nddr_rd_capture #(.DQ_W(DQ_W), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .arm(rd_arm), .clr(rd_clr), .len_i(len_q),
    .dqs_in(nd_dqs_in), .dq_in(nd_dq_in), .vld(rd_valid), .data(rd_data),
    .done(rd_done)
  );

  assign wr_take   = load_pair;
  assign nd_dq_out = ca_act ? ca_byte : wr_byte;
  assign nd_dq_oe  = ca_act || wr_act;
  assign nd_dqs_oe = wr_act;

  AST_CA_NO_DQS: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_cle != nd_ale) |-> !nd_dqs_oe); // R2
  AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    nd_dqs_oe |-> (nd_cle && nd_ale && nd_wr_n)); // R4
endmodule

// File: tb/nand_ddr_host_tb.sv
module nand_ddr_host_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd2;
  logic [7:0]  cfg_tcad = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_byte = 8'd0;
  logic [11:0] req_len = 12'd0;
  logic [15:0] wr_data;
  logic        wr_take, rd_valid, busy;
  logic [7:0]  rd_data;
  logic        nd_clk, nd_wr_n, nd_cle, nd_ale, nd_dq_oe, nd_dqs_out, nd_dqs_oe;
  logic [7:0]  nd_dq_out;
  logic [7:0]  nd_dq_in = 8'd0;
  logic        nd_dqs_in = 1'b0;

  always #5 clk = ~clk;

  nand_ddr_host u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_tcad(cfg_tcad),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_byte(req_byte), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .nd_clk(nd_clk), .nd_wr_n(nd_wr_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
    .nd_dq_out(nd_dq_out), .nd_dq_oe(nd_dq_oe), .nd_dq_in(nd_dq_in),
    .nd_dqs_out(nd_dqs_out), .nd_dqs_oe(nd_dqs_oe), .nd_dqs_in(nd_dqs_in)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // write word source: word w carries bytes 2w (low) and 2w+1 (high)
  logic [7:0] widx = 8'd0;
  int         ntake = 0;
  assign wr_data = {widx[6:0], 1'b1, widx[6:0], 1'b0};
  always @(posedge clk) if (wr_take) begin widx <= widx + 8'd1; ntake <= ntake + 1; end

  // monitor
  int   cyc = 0, t_rise = 0, t_rise_prev = 0, t_fall = 0, t_busy_fall = 0, t_dir = 0, t_last_rd = 0;
  int   ncle, nale, ndata, nclk_rise, nclk_hi, ca_byte, ca_dqs_bad, dir_bad, clk_bad;
  int   wcnt, rcnt;
  logic [7:0] wbuf [0:63];
  logic [7:0] rbuf [0:63];
  logic p_sel = 1'b0, p_busy = 1'b0, p_dir = 1'b1, p_clk = 1'b0, p_dqs = 1'b0;

  task automatic clr_mon();
    ncle = 0; nale = 0; ndata = 0; nclk_rise = 0; nclk_hi = 0; ca_byte = -1;
    ca_dqs_bad = 0; dir_bad = 0; clk_bad = 0; wcnt = 0; rcnt = 0; ntake = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if ((nd_cle || nd_ale) && !p_sel) begin t_rise_prev = t_rise; t_rise = cyc; end
    if (!(nd_cle || nd_ale) && p_sel) t_fall = cyc;
    if (!busy && p_busy) t_busy_fall = cyc;
    if (nd_wr_n != p_dir) begin t_dir = cyc; if (nd_cle || nd_ale) dir_bad++; end
    if (nd_cle) ncle++;
    if (nd_ale) nale++;
    if (nd_cle && nd_ale) ndata++;
    if (nd_clk && !p_clk) nclk_rise++;
    if (nd_clk) nclk_hi++;
    if (nd_clk && !(nd_cle || nd_ale)) clk_bad++;
    if (nd_clk && (nd_cle != nd_ale)) ca_byte = int'(nd_dq_out);
    if ((nd_cle != nd_ale) && nd_dqs_oe) ca_dqs_bad++;
    if (nd_dqs_oe && nd_dqs_out != p_dqs && wcnt < 64) begin wbuf[wcnt] = nd_dq_out; wcnt++; end
    if (rd_valid && rcnt < 64) begin rbuf[rcnt] = rd_data; rcnt++; t_last_rd = cyc; end
    p_sel = nd_cle || nd_ale; p_busy = busy; p_dir = nd_wr_n; p_clk = nd_clk; p_dqs = nd_dqs_out;
  end

  // ideal device for reads: strobe edge-aligned with data, delayed dev_dly cycles
  int       dev_dly = 1, dev_extra = 0, dev_sent = 0, dev_len = 0, dev_xleft = 0;
  logic [7:0] dev_base = 8'd0;
  logic [7:0] dev_pipe = 8'd0;
  logic       dev_cprev = 1'b0, dev_e;
  always @(negedge clk) begin
    dev_e = nd_cle && nd_ale && !nd_wr_n && (nd_clk != dev_cprev);
    dev_cprev = nd_clk;
    dev_pipe = {dev_pipe[6:0], dev_e};
    if (dev_pipe[dev_dly-1]) begin
      nd_dqs_in = ~nd_dqs_in;
      nd_dq_in  = dev_base + 8'(dev_sent);
      dev_sent++;
      if (dev_sent == dev_len) dev_xleft = dev_extra;
    end else if (dev_xleft > 0) begin
      nd_dqs_in = ~nd_dqs_in;
      nd_dq_in  = 8'hEE;
      dev_xleft--;
    end
  end

  task automatic send(input logic [1:0] op, input logic [7:0] b, input int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_byte = b; req_len = 12'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic begin_case(input int half, input int tcad);
    @(posedge clk);
    cfg_half = 8'(half); cfg_tcad = 8'(tcad);
    clr_mon();
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 clk/cle/ale", int'({nd_clk, nd_cle, nd_ale}), 0);
    chk("R1 wr_n", int'(nd_wr_n), 1);
    chk("R1 oe/rd_valid", int'({nd_dq_oe, nd_dqs_oe, rd_valid}), 0);
  endtask

  task automatic t_cmd();
    begin_case(3, 4);
    send(2'd0, 8'h5A, 0);
    wait_idle();
    chk("R2 cle cycles", ncle, 6);
    chk("R2 ale unused", nale, 0);
    chk("R2 byte on bus", ca_byte, 'h5A);
    chk("R2 no strobe", ca_dqs_bad, 0);
    chk("R9 clk high length", nclk_hi, 3);
    chk("R9 one period", nclk_rise, 1);
    chk("R3 spacing to busy low", t_busy_fall - t_fall, 4);
  endtask

  task automatic t_addr_pair();
    begin_case(2, 5);
    send(2'd1, 8'h11, 0);
    send(2'd1, 8'h22, 0);
    wait_idle();
    chk("R3 back-to-back spacing", t_rise - t_rise_prev, 10);
    chk("R2 ale cycles", nale, 8);
    chk("R2 cle unused", ncle, 0);
    chk("R2 last address byte", ca_byte, 'h22);
  endtask

  task automatic t_write(input int half, input int len, input int turn);
    int w0;
    begin_case(half, 2);
    w0 = int'(widx);
    send(2'd2, 8'h00, len);
    wait_idle();
    chk("R4 data cycles", ndata, len * half);
    chk("R4 clk periods", nclk_rise, len / 2);
    chk("R4 word takes", ntake, len / 2);
    chk("R4 strobed bytes", wcnt, len);
    for (int k = 0; k < len && k < wcnt; k++)
      chk("R4 byte order", int'(wbuf[k]), (2 * w0 + k) % 256);
    if (turn != 0) begin
      chk("R7 turnaround to data", t_rise - t_dir, 2 * half);
      chk("R7 direction quiet", dir_bad, 0);
    end
    chk("R8 clock gated", clk_bad, 0);
  endtask

  task automatic t_read(input int half, input int dly, input int extra, input logic [7:0] base,
                        input int turn);
    begin_case(half, 2);
    dev_dly = dly; dev_extra = extra; dev_sent = 0; dev_len = 8; dev_base = base;
    send(2'd3, 8'h00, 8);
    wait_idle();
    chk("R5 data cycles", ndata, 8 * half);
    chk("R5 byte count", rcnt, 8);
    for (int k = 0; k < 8 && k < rcnt; k++)
      chk("R5 byte order", int'(rbuf[k]), (int'(base) + k) % 256);
    chk("R6 done after last byte", int'(t_busy_fall > t_last_rd), 1);
    if (turn != 0) begin
      chk("R7 turnaround to data", t_rise - t_dir, 2 * half);
      chk("R7 direction quiet", dir_bad, 0);
      chk("R7 read direction", int'(nd_wr_n), 0);
    end
    chk("R8 clock gated", clk_bad, 0);
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_cmd();
    t_addr_pair();
    t_write(2, 6, 0);
    t_read(3, 2, 0, 8'h40, 1);        // prompt strobe, write->read reversal
    t_read(2, 7, 0, 8'h80, 0);        // strobe lags past end of clock (R6)
    t_read(4, 1, 2, 8'hC0, 0);        // surplus strobe edges ignored (R6)
    t_write(2, 4, 1);                 // read->write reversal
    begin_case(2, 1);
    send(2'd0, 8'hA5, 0);
    wait_idle();
    chk("R2 command after write", ca_byte, 'hA5);
    chk("R9 short period", nclk_hi, 2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule